// File: doc/BRIEF.md
# Release-Aligned Fast-Clock Divider

This block turns a fast edge clock into a slower system clock, dividing by 2, 4 or 8. The ratio comes from a two-bit select input. The phase of the slow clock relative to the fast clock is not left to chance. It is fixed by the fast-clock edge on which the block is let go, so every start produces the same alignment. Alongside the divided clock, the block gives a one-fast-cycle strobe that marks each rising edge of the divided clock. Logic in the fast domain can use this strobe to tell where the slow clock is in its cycle.

An asynchronous reset clears the block at once. After that, the block waits for its release input. Nothing moves until release is sampled high on a fast rising edge. Dropping release while the block runs stops it cleanly on the next edge. A later release restarts it from the same phase. The divided output is a registered logic signal.

The controller has two states:
- `ST_HOLD`: the phase counter is held at zero, both outputs are low, and the ratio select is captured on every edge.
- `ST_RUN`: the counter advances each edge, and the ratio is frozen.

It has two transitions:
- `HOLD->RUN`: taken on an edge where release is high.
- `RUN->HOLD`: taken on an edge where release is low.

Asynchronous reset forces `ST_HOLD` from either state.

Top module: `edge_clk_divider`

## Requirements
- R1: The ratio select encoding is `00` for divide-by-2, `01` for divide-by-4, and `10` or `11` for divide-by-8. While running, the divided clock repeats with a period of N fast cycles, where N is the selected ratio.
- R2: Raising `rst_async` drives `div_clk` and `div_rise` low at once, with no fast-clock edge needed.
- R3: After reset, both outputs stay low on every fast edge until one on which `release_en` is sampled high.
- R4: On the first fast rising edge with `release_en` high in `ST_HOLD`, `div_clk` and `div_rise` both go high after that edge. The first divided rising edge therefore always lands at a fixed offset from release.
- R5: While running, `div_clk` is high for N/2 fast cycles and then low for N/2 fast cycles.
- R6: `div_rise` is high for exactly one fast cycle at each rising edge of `div_clk` and is low at all other times.
- R7: The block uses the ratio select value present on the release edge. Changes to the select while running have no effect on the output until the block returns to `ST_HOLD`.
- R8: `release_en` sampled low while running drives both outputs low after that edge. The block then stays idle until release returns, and it restarts as in R4.
- R9: For the same ratio, each reset followed by a release yields the same output waveform relative to the release edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast edge clock being divided |
| rst_async | input | 1 | Asynchronous reset, active high |
| release_en | input | 1 | Starts or keeps the divider running when sampled high |
| ratio_sel | input | 2 | Division ratio select (see R1) |
| div_clk | output | 1 | Divided clock, registered |
| div_rise | output | 1 | One-fast-cycle strobe on each rising edge of `div_clk` |

## Verification
Every synchronous result is due one register stage after the fast edge that samples the inputs. After the release edge, the output shows phase 0. After the k-th edge that follows, it shows phase k mod N. The bench drives inputs on the falling edge, moves its reference model on the rising edge, and compares at the next falling edge, so each check reads exactly one edge's worth of change. The reset result is due without any edge: the bench raises reset halfway through the low phase of the fast clock and compares one time unit later, before any rising edge.

// File: rtl/edge_clk_divider_pkg.sv
package edge_clk_divider_pkg;

    localparam int SEL_W     = 2;
    localparam int MAX_LOG2  = 3;
    localparam int PHASE_W   = MAX_LOG2;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } div_state_t;

    // last phase index (N-1) for a select code
    function automatic logic [PHASE_W-1:0] sel_to_last(input logic [SEL_W-1:0] sel);
        logic [PHASE_W-1:0] r;
        unique case (sel)
            2'b00:   r = PHASE_W'(1);
            2'b01:   r = PHASE_W'(3);
            default: r = PHASE_W'(7);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/edge_clk_ratio_latch.sv
module edge_clk_ratio_latch
    import edge_clk_divider_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic [SEL_W-1:0]   sel,
    output logic [PHASE_W-1:0] last_q,
    output logic [PHASE_W-1:0] half_q
);

    logic [PHASE_W-1:0] last_d;

    always_comb begin
        last_d = sel_to_last(sel);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            last_q <= PHASE_W'(1);
            half_q <= PHASE_W'(1);
        end else if (capture) begin
            last_q <= last_d;
            half_q <= PHASE_W'((32'(last_d) + 1) >> 1);
        end
    end

    // frozen ratio while not capturing
    AST_RATIO_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !$past(capture) |-> $stable(last_q) && $stable(half_q)); // R7

endmodule

// File: rtl/edge_clk_phase_ctr.sv
module edge_clk_phase_ctr
    import edge_clk_divider_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic [PHASE_W-1:0] last,
    output logic [PHASE_W-1:0] phase_q,
    output logic [PHASE_W-1:0] phase_nxt
);

    always_comb begin
        if (clear) begin
            phase_nxt = '0;
        end else if (phase_q == last) begin
            phase_nxt = '0;
        end else begin
            phase_nxt = phase_q + PHASE_W'(1);
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_nxt;
        end
    end

    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        !clear |-> phase_q <= last); // R1

    AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $past(clear) |-> phase_q == '0); // R8

endmodule

// File: rtl/edge_clk_divider.sv
module edge_clk_divider
    import edge_clk_divider_pkg::*;
(
    input  logic             clk_fast,
    input  logic             rst_async,
    input  logic             release_en,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic             div_clk,
    output logic             div_rise
);

    div_state_t         state_q;
    div_state_t         state_d;
    logic [PHASE_W-1:0] last_q;
    logic [PHASE_W-1:0] half_q;
    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] phase_nxt;
    logic               in_hold;
    logic               ctr_clear;

    assign in_hold   = (state_q == ST_HOLD);
    assign ctr_clear = in_hold || !release_en;

    edge_clk_ratio_latch u_ratio (
        .clk     (clk_fast),
        .rst     (rst_async),
        .capture (in_hold),
        .sel     (ratio_sel),
        .last_q  (last_q),
        .half_q  (half_q)
    );

    edge_clk_phase_ctr u_phase (
        .clk       (clk_fast),
        .rst       (rst_async),
        .clear     (ctr_clear),
        .last      (last_q),
        .phase_q   (phase_q),
        .phase_nxt (phase_nxt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (release_en)  state_d = ST_RUN;
            ST_RUN:  if (!release_en) state_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk_fast or posedge rst_async) begin
        if (rst_async) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk_fast or posedge rst_async) begin
        if (rst_async) begin
            div_clk  <= 1'b0;
            div_rise <= 1'b0;
        end else begin
            unique case (state_q)
                ST_HOLD: begin
                    div_clk  <= release_en;
                    div_rise <= release_en;
                end
                ST_RUN: begin
                    if (release_en) begin
                        div_clk  <= (phase_nxt < half_q);
                        div_rise <= (phase_nxt == '0);
                    end else begin
                        div_clk  <= 1'b0;
                        div_rise <= 1'b0;
                    end
                end
            endcase
        end
    end

    AST_IDLE_LOW: assert property (@(posedge clk_fast) disable iff (rst_async)
        !$past(release_en) |-> !div_clk && !div_rise); // R3

    AST_FIRST_RISE: assert property (@(posedge clk_fast) disable iff (rst_async)
        (in_hold && release_en) |=> div_clk && div_rise); // R4

    AST_STB_SINGLE: assert property (@(posedge clk_fast) disable iff (rst_async)
        div_rise |=> !div_rise); // R6

    AST_STB_ON_RISE: assert property (@(posedge clk_fast) disable iff (rst_async)
        $rose(div_clk) |-> div_rise); // R6

    AST_STB_WITH_HIGH: assert property (@(posedge clk_fast) disable iff (rst_async)
        div_rise |-> div_clk); // R6

endmodule

// File: tb/test_edge_clk_divider.sv
module test_edge_clk_divider;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk_fast = 1'b0;
    logic       rst_async = 1'b1;
    logic       release_en = 1'b0;
    logic [1:0] ratio_sel = 2'b00;
    logic       div_clk;
    logic       div_rise;

    int n_cmp  = 0;
    int n_bad  = 0;
    int cycles = 0;
    bit done   = 0;

    // reference model state
    bit m_run  = 0;
    int m_ph   = 0;
    int m_n    = 2;

    edge_clk_divider i_edge_clk_divider (
        .clk_fast   (clk_fast),
        .rst_async  (rst_async),
        .release_en (release_en),
        .ratio_sel  (ratio_sel),
        .div_clk    (div_clk),
        .div_rise   (div_rise)
    );

    always #(CLK_PERIOD/2) clk_fast = ~clk_fast;

    function automatic int ratio_of(input logic [1:0] s);
        case (s)
            2'b00:   return 2;
            2'b01:   return 4;
            default: return 8;
        endcase
    endfunction

    function automatic bit exp_div();
        return m_run && (m_ph < m_n / 2);
    endfunction

    function automatic bit exp_rise();
        return m_run && (m_ph == 0);
    endfunction

    task automatic model_edge(input logic r, input logic rel, input logic [1:0] s);
        if (r) begin
            m_run = 0; m_ph = 0; m_n = 2;
        end else if (!m_run) begin
            m_n = ratio_of(s);
            if (rel) begin m_run = 1; m_ph = 0; end
        end else if (!rel) begin
            m_run = 0; m_ph = 0;
        end else begin
            m_ph = (m_ph + 1) % m_n;
        end
    endtask

    task automatic cmp(input string tag, input logic act, input bit exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_outs(input string tag);
        string td;
        string tr;
        td = tag; tr = tag;
        if (tag == "") begin
            if (!m_run)        begin td = "R3"; tr = "R3"; end
            else if (m_ph == 0) begin td = "R4"; tr = "R6"; end
            else               begin td = "R5"; tr = "R6"; end
        end
        cmp(td, div_clk, exp_div(), "div_clk");
        cmp(tr, div_rise, exp_rise(), "div_rise");
    endtask

    // called at a falling edge; ends at the next falling edge after checking
    task automatic step(input logic rel, input logic [1:0] s, input string tag);
        release_en = rel;
        ratio_sel  = s;
        @(posedge clk_fast);
        model_edge(rst_async, rel, s);
        @(negedge clk_fast);
        check_outs(tag);
    endtask

    // asynchronous reset pulse, checked before any rising edge
    task automatic async_reset();
        #(CLK_PERIOD/4);
        rst_async = 1'b1;
        #1;
        n_cmp++;
        if (div_clk !== 1'b0 || div_rise !== 1'b0) begin
            n_bad++;
            $display("FAIL R2 async reset actual=%0b%0b expected=00 at %0t", div_clk, div_rise, $time);
        end
        model_edge(1'b1, 1'b0, 2'b00);
        @(negedge clk_fast);
        step(1'b0, 2'b00, "R2");
        rst_async = 1'b0;
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk_fast);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                n_bad++;
                $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'd1234));
        @(negedge clk_fast);
        check_outs("R2");
        step(1'b0, 2'b01, "R2");
        rst_async = 1'b0;
        // idle: release low
        for (int i = 0; i < 5; i++) step(1'b0, 2'(i), "R3");

        // each ratio, including code 11
        for (int c = 0; c < 4; c++) begin
            step(1'b1, 2'(c), "R4");
            for (int i = 0; i < 3 * 8; i++) step(1'b1, 2'(c), "R1");
            step(1'b0, 2'(c), "R8");
            step(1'b0, 2'(c), "R8");
        end

        // ratio change while running is ignored
        step(1'b1, 2'b01, "R4");
        for (int i = 0; i < 16; i++) step(1'b1, 2'(i % 4), "R7");

        // drop release mid-period, then restart
        step(1'b1, 2'b10, "R8");
        step(1'b0, 2'b10, "R8");
        step(1'b1, 2'b10, "R8");
        for (int i = 0; i < 9; i++) step(1'b1, 2'b00, "R5");

        // repeated reset + release gives the same waveform
        for (int k = 0; k < 3; k++) begin
            async_reset();
            step(1'b0, 2'b01, "R9");
            step(1'b1, 2'b01, "R9");
            for (int i = 0; i < 8; i++) step(1'b1, 2'b01, "R9");
        end

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 299) == 0) begin
                async_reset();
            end else begin
                step(($urandom_range(0, 15) != 0), 2'($urandom_range(0, 3)), "");
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule